// File: doc/BRIEF.md
# Retention power-down sequencer

This block is an always-on state machine that moves a processor out of deep sleep into state-retention power gating and brings it back. When the processor reports that it is sleeping in its deep mode and the external wake-event detector is enabled, the block asks the processor to stay asleep through an active-low hold request. Once the processor grants the hold with its active-low acknowledge, the block removes the processor clock, clamps the domain outputs with isolation, saves state into the retention cells and finally cuts power.

A wake request from the always-on wake-event detector reverses these steps. Power comes back first. The block then waits for the power-good status before it restores state, removes isolation and restarts the clock. Only after all of that does it drop the hold request, so the processor resumes execution on a ready system. If the processor never acknowledges the hold, it is already waking, and the block backs out without touching any other control. With the early-cancel option built in, a wake request that arrives before power is removed unwinds the steps taken so far and never cuts power.

Every control step is held for a parameterised number of clock cycles, `STEP_CYCLES`, before the next control signal moves. This gives the analog switches and the retention cells time to settle.

Top module: `pd_sequencer`

## Requirements
- R1: `hold_req_n_o` goes low on the clock edge after a cycle in which `cpu_sleeping_i`, `cpu_deep_i` and `wake_unit_en_i` are all high while the block is idle; the request is the first control to change.
- R2: While the hold request is low and `hold_ack_n_i` stays high, no other output changes. If `cpu_sleeping_i` falls before an acknowledge arrives, `hold_req_n_o` returns high on the next edge.
- R3: A low `hold_ack_n_i` during the hold request makes `clk_en_o` fall on the next edge.
- R4: Entry order is: clock off, then `iso_n_o` low, then `ret_n_o` low, then `pwr_off_o` high. Each change comes exactly `STEP_CYCLES` cycles after the previous one.
- R5: `pwr_off_o` stays high, once it has been high for `STEP_CYCLES` cycles, until `wakeup_i` is seen high. It falls on the edge after that.
- R6: After `pwr_off_o` falls, `ret_n_o` rises only after at least `STEP_CYCLES` cycles. It rises on the edge after `pwr_ready_i` is seen high once that time has passed.
- R7: Wake order is: `ret_n_o` high, then `iso_n_o` high, then `clk_en_o` high, then `hold_req_n_o` high, each `STEP_CYCLES` cycles apart. At release, all controls are back at their run values.
- R8: After a release, no new hold request is issued until `cpu_sleeping_i` has been seen low.
- R9: With `ABORT_EN`=1, `wakeup_i` seen high at the end of the clock-off, isolate or retain step reverses the latest step instead of advancing, and `pwr_off_o` never rises. With `ABORT_EN`=0, such a wake request is ignored until power is off.
- R10: Every change of `iso_n_o`, `ret_n_o` or `pwr_off_o`, and every rise of `clk_en_o`, comes at least `STEP_CYCLES` cycles after the previous control change.
- R11: Reset gives `hold_req_n_o`=1, `clk_en_o`=1, `iso_n_o`=1, `ret_n_o`=1 and `pwr_off_o`=0.
- R12: With `wake_unit_en_i` or `cpu_deep_i` low, a sleeping processor never gets a hold request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sleeping_i | input | 1 | Processor reports it is in sleep |
| cpu_deep_i | input | 1 | Sleep is the deep variety |
| wake_unit_en_i | input | 1 | Wake-event detector is armed and power gating is allowed |
| hold_ack_n_i | input | 1 | Processor grants the sleep hold, active low |
| wakeup_i | input | 1 | Wake request from the wake-event detector |
| pwr_ready_i | input | 1 | Domain supply has finished ramping up |
| hold_req_n_o | output | 1 | Sleep hold request to the processor, active low |
| clk_en_o | output | 1 | Enable for the processor clock gate |
| iso_n_o | output | 1 | Isolation clamp control, active low |
| ret_n_o | output | 1 | Retention save/restore control, active low |
| pwr_off_o | output | 1 | Power switch off request |

## Verification
Checked on every cycle:
- The entry and wake ordering at the ports: isolation only after the clock is off, power-off only after retention, and release only with every control back at its run value.
- That the hold request starts only from a deep sleep with the detector enabled.
- That the clock is gated only after an acknowledge.
- That no timed control moves before its dwell has elapsed, checked with a cycle counter.

Shown only by the bench's scenarios:
- The exact dwell lengths.
- The no-acknowledge back-out.
- The wait for power-good.
- The refusal to re-enter before sleep is seen low.
- The abort paths from each step, compared against a copy built without the cancel option.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

   typedef enum logic [3:0] {
      ST_RUN     = 4'd0,
      ST_HOLD    = 4'd1,
      ST_CLK_OFF = 4'd2,
      ST_ISO     = 4'd3,
      ST_RET     = 4'd4,
      ST_PDN     = 4'd5,
      ST_PUP     = 4'd6,
      ST_UNRET   = 4'd7,
      ST_UNISO   = 4'd8,
      ST_CLK_ON  = 4'd9,
      ST_REL     = 4'd10
   } pd_state_e;

   typedef struct packed {
      logic hold_req_n;
      logic clk_en;
      logic iso_n;
      logic ret_n;
      logic pwr_off;
   } pd_ctrl_t;

   localparam pd_ctrl_t CTRL_IDLE = '{hold_req_n: 1'b1, clk_en: 1'b1,
                                      iso_n: 1'b1, ret_n: 1'b1, pwr_off: 1'b0};

   // Control levels held in each state.
   function automatic pd_ctrl_t ctrl_of(pd_state_e s);
      pd_ctrl_t c;
      c = CTRL_IDLE;
      unique case (s)
         ST_RUN, ST_REL: c = CTRL_IDLE;
         ST_HOLD, ST_CLK_ON: begin
            c.hold_req_n = 1'b0;
         end
         ST_CLK_OFF, ST_UNISO: begin
            c.hold_req_n = 1'b0;
            c.clk_en     = 1'b0;
         end
         ST_ISO, ST_UNRET: begin
            c.hold_req_n = 1'b0;
            c.clk_en     = 1'b0;
            c.iso_n      = 1'b0;
         end
         ST_RET, ST_PUP: begin
            c.hold_req_n = 1'b0;
            c.clk_en     = 1'b0;
            c.iso_n      = 1'b0;
            c.ret_n      = 1'b0;
         end
         ST_PDN: begin
            c.hold_req_n = 1'b0;
            c.clk_en     = 1'b0;
            c.iso_n      = 1'b0;
            c.ret_n      = 1'b0;
            c.pwr_off    = 1'b1;
         end
         default: c = CTRL_IDLE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pd_seq_timer.sv
module pd_seq_timer #(
   parameter int STEP_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic done_o
);
   localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;

   // Counts cycles spent in the current state, saturating at the dwell end.
   always_comb begin
      if (restart_i)          cnt_d = '0;
      else if (cnt_q == LAST) cnt_d = cnt_q;
      else                    cnt_d = cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign done_o = (cnt_q == LAST);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);  // R10
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
   import pd_seq_pkg::*;
#(
   parameter bit ABORT_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cpu_sleeping_i,
   input  logic      cpu_deep_i,
   input  logic      wake_unit_en_i,
   input  logic      hold_ack_n_i,
   input  logic      wakeup_i,
   input  logic      pwr_ready_i,
   input  logic      step_done_i,
   output pd_state_e state_d_o,
   output logic      restart_o
);
   pd_state_e state_q;
   pd_state_e state_d;
   logic      cancel;
   logic      entry_ok;

   // The option chooses whether an early wake request may cancel entry.
   generate
      if (ABORT_EN) begin : g_cancel
         assign cancel = wakeup_i;
      end else begin : g_no_cancel
         assign cancel = 1'b0;
      end
   endgenerate

   assign entry_ok = cpu_sleeping_i & cpu_deep_i & wake_unit_en_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:     if (entry_ok) state_d = ST_HOLD;
         ST_HOLD: begin
            if (!hold_ack_n_i)        state_d = ST_CLK_OFF;
            else if (!cpu_sleeping_i) state_d = ST_RUN;
         end
         ST_CLK_OFF: if (step_done_i) state_d = cancel ? ST_CLK_ON : ST_ISO;
         ST_ISO:     if (step_done_i) state_d = cancel ? ST_UNISO  : ST_RET;
         ST_RET:     if (step_done_i) state_d = cancel ? ST_UNRET  : ST_PDN;
         ST_PDN:     if (step_done_i && wakeup_i)    state_d = ST_PUP;
         ST_PUP:     if (step_done_i && pwr_ready_i) state_d = ST_UNRET;
         ST_UNRET:   if (step_done_i) state_d = ST_UNISO;
         ST_UNISO:   if (step_done_i) state_d = ST_CLK_ON;
         ST_CLK_ON:  if (step_done_i) state_d = ST_REL;
         ST_REL:     if (!cpu_sleeping_i) state_d = ST_RUN;
         default:    state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   assign state_d_o = state_d;
   assign restart_o = (state_d != state_q);

   AST_BACKOUT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && hold_ack_n_i && !cpu_sleeping_i) |=> (state_q == ST_RUN));  // R2
   AST_NO_REENTRY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REL && cpu_sleeping_i) |=> (state_q == ST_REL));  // R8
   AST_PDN_WAITS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PDN && !wakeup_i) |=> (state_q == ST_PDN));  // R5
endmodule

// File: rtl/pd_seq_ctrl_reg.sv
module pd_seq_ctrl_reg
   import pd_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pd_state_e state_d_i,
   output pd_ctrl_t  ctrl_o
);
   pd_ctrl_t ctrl_q;

   // Outputs come straight from flops so the analog controls never glitch.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= CTRL_IDLE;
      else        ctrl_q <= ctrl_of(state_d_i);
   end

   assign ctrl_o = ctrl_q;

   AST_OFF_MEANS_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.pwr_off |-> (!ctrl_q.iso_n && !ctrl_q.ret_n && !ctrl_q.clk_en));  // R4
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
   import pd_seq_pkg::*;
#(
   parameter int STEP_CYCLES = 4,
   parameter bit ABORT_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_sleeping_i,
   input  logic cpu_deep_i,
   input  logic wake_unit_en_i,
   input  logic hold_ack_n_i,
   input  logic wakeup_i,
   input  logic pwr_ready_i,
   output logic hold_req_n_o,
   output logic clk_en_o,
   output logic iso_n_o,
   output logic ret_n_o,
   output logic pwr_off_o
);
   localparam int QW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
   localparam logic [QW-1:0] QMAX = QW'(STEP_CYCLES - 1);

   generate
      if (STEP_CYCLES < 1) begin : g_bad_step
         $error("STEP_CYCLES must be at least 1");
      end
   endgenerate

   pd_state_e state_d;
   logic      restart;
   logic      step_done;
   pd_ctrl_t  ctrl;

   pd_seq_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .done_o    (step_done)
   );

   pd_seq_fsm #(.ABORT_EN(ABORT_EN)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_sleeping_i (cpu_sleeping_i),
      .cpu_deep_i     (cpu_deep_i),
      .wake_unit_en_i (wake_unit_en_i),
      .hold_ack_n_i   (hold_ack_n_i),
      .wakeup_i       (wakeup_i),
      .pwr_ready_i    (pwr_ready_i),
      .step_done_i    (step_done),
      .state_d_o      (state_d),
      .restart_o      (restart)
   );

   pd_seq_ctrl_reg u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_d_i (state_d),
      .ctrl_o    (ctrl)
   );

   assign hold_req_n_o = ctrl.hold_req_n;
   assign clk_en_o     = ctrl.clk_en;
   assign iso_n_o      = ctrl.iso_n;
   assign ret_n_o      = ctrl.ret_n;
   assign pwr_off_o    = ctrl.pwr_off;

   // Dwell monitor: cycles since the last change of any control output.
   pd_ctrl_t        prev_q;
   logic [QW-1:0]   quiet_q;
   logic            any_chg;
   logic            timed_chg;

   assign any_chg   = (ctrl != prev_q);
   assign timed_chg = (ctrl.iso_n != prev_q.iso_n) || (ctrl.ret_n != prev_q.ret_n) ||
                      (ctrl.pwr_off != prev_q.pwr_off) || (ctrl.clk_en && !prev_q.clk_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= CTRL_IDLE;
         quiet_q <= '0;
      end else begin
         prev_q <= ctrl;
         if (any_chg)            quiet_q <= '0;
         else if (quiet_q != QMAX) quiet_q <= quiet_q + QW'(1);
      end
   end

   AST_DWELL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      timed_chg |-> (quiet_q == QMAX));  // R10
   AST_REQ_AFTER_DEEP_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_req_n_o) |-> $past(cpu_sleeping_i && cpu_deep_i && wake_unit_en_i));  // R1
   AST_GATE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en_o) |-> ($past(!hold_ack_n_i) && !hold_req_n_o));  // R3
   AST_ISO_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_n_o) |-> (!clk_en_o && $past(!clk_en_o)));  // R4
   AST_OFF_AFTER_RET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_off_o) |-> ($past(!ret_n_o) && $past(!iso_n_o)));  // R4
   AST_ON_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_off_o) |-> $past(wakeup_i));  // R5
   AST_RELEASE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_req_n_o) |-> (clk_en_o && iso_n_o && ret_n_o && !pwr_off_o));  // R7

   generate
      if (!ABORT_EN) begin : g_ready_chk
         AST_RESTORE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ret_n_o) |-> $past(pwr_ready_i));  // R6
      end
   endgenerate
endmodule

// File: tb/test_pd_sequencer.sv
module test_pd_sequencer;
   localparam int S = 3;

   typedef enum int {P_RUN, P_HOLD, P_CLK_OFF, P_ISO, P_RET, P_PDN, P_PUP,
                     P_UNRET, P_UNISO, P_CLK_ON, P_REL} ph_e;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleeping = 1'b0, deep = 1'b0, en = 1'b0, ack_n = 1'b1, wake = 1'b0, ready = 1'b0;
   logic hr_a, ce_a, is_a, rt_a, po_a;
   logic hr_b, ce_b, is_b, rt_b, po_b;
   logic [4:0] v_a, v_b;
   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pd_sequencer #(.STEP_CYCLES(S), .ABORT_EN(1'b1)) i_pd_sequencer (
      .clk(clk), .rst_n(rst_n), .cpu_sleeping_i(sleeping), .cpu_deep_i(deep),
      .wake_unit_en_i(en), .hold_ack_n_i(ack_n), .wakeup_i(wake), .pwr_ready_i(ready),
      .hold_req_n_o(hr_a), .clk_en_o(ce_a), .iso_n_o(is_a), .ret_n_o(rt_a), .pwr_off_o(po_a));

   pd_sequencer #(.STEP_CYCLES(S), .ABORT_EN(1'b0)) i_pd_sequencer_noabort (
      .clk(clk), .rst_n(rst_n), .cpu_sleeping_i(sleeping), .cpu_deep_i(deep),
      .wake_unit_en_i(en), .hold_ack_n_i(ack_n), .wakeup_i(wake), .pwr_ready_i(ready),
      .hold_req_n_o(hr_b), .clk_en_o(ce_b), .iso_n_o(is_b), .ret_n_o(rt_b), .pwr_off_o(po_b));

   assign v_a = {hr_a, ce_a, is_a, rt_a, po_a};
   assign v_b = {hr_b, ce_b, is_b, rt_b, po_b};

   // Expected {hold_req_n, clk_en, iso_n, ret_n, pwr_off} for each phase.
   function automatic logic [4:0] exp_vec(ph_e p);
      case (p)
         P_RUN, P_REL:      return 5'b11110;
         P_HOLD, P_CLK_ON:  return 5'b01110;
         P_CLK_OFF, P_UNISO: return 5'b00110;
         P_ISO, P_UNRET:    return 5'b00010;
         P_RET, P_PUP:      return 5'b00000;
         P_PDN:             return 5'b00001;
         default:           return 5'b11110;
      endcase
   endfunction

   task automatic chk(string req, string who, logic [4:0] got, logic [4:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s (%s): got %b expected %b at %0t", req, who, got, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic dwell(ph_e cur, ph_e nxt, string req);
      for (int i = 1; i < S; i++) begin
         tick();
         chk(req, "dwell", v_a, exp_vec(cur));
      end
      tick();
      chk(req, "step", v_a, exp_vec(nxt));
   endtask

   task automatic settle();
      sleeping = 0; deep = 0; en = 0; ack_n = 1; wake = 1; ready = 1;
      repeat (14 * S + 10) tick();
      wake = 0; ready = 0;
      tick();
      chk("R8", "idle A", v_a, exp_vec(P_RUN));
      chk("R8", "idle B", v_b, exp_vec(P_RUN));
   endtask

   task automatic full_cycle(int ack_lat, int pd_wait, int rdy_lat);
      sleeping = 1; deep = 1; en = 1;
      tick(); chk("R1", "request", v_a, exp_vec(P_HOLD));
      for (int i = 0; i < ack_lat; i++) begin
         tick(); chk("R2", "wait ack", v_a, exp_vec(P_HOLD));
      end
      ack_n = 0;
      tick(); chk("R3", "gate", v_a, exp_vec(P_CLK_OFF));
      dwell(P_CLK_OFF, P_ISO, "R4");
      dwell(P_ISO, P_RET, "R4");
      dwell(P_RET, P_PDN, "R4");
      chk("R9", "no-cancel copy", v_b, exp_vec(P_PDN));
      for (int i = 0; i < pd_wait; i++) begin
         tick(); chk("R5", "off", v_a, exp_vec(P_PDN));
      end
      wake = 1;
      tick(); chk("R5", "power on", v_a, exp_vec(P_PUP));
      wake = 0; ack_n = 1;
      for (int i = 0; i < rdy_lat; i++) begin
         tick(); chk("R6", "wait ready", v_a, exp_vec(P_PUP));
      end
      ready = 1;
      tick(); chk("R6", "restore", v_a, exp_vec(P_UNRET));
      dwell(P_UNRET, P_UNISO, "R7");
      dwell(P_UNISO, P_CLK_ON, "R7");
      dwell(P_CLK_ON, P_REL, "R7");
      for (int i = 0; i < 3; i++) begin
         tick(); chk("R8", "still asleep", v_a, exp_vec(P_REL));
      end
      sleeping = 0; deep = 0; en = 0; ready = 0;
      tick(); chk("R8", "back to run", v_a, exp_vec(P_RUN));
      chk("R7", "copy back", v_b, exp_vec(P_RUN));
   endtask

   task automatic abort_cycle(int at);
      sleeping = 1; deep = 1; en = 1;
      tick(); chk("R1", "request", v_a, exp_vec(P_HOLD));
      ack_n = 0;
      tick(); chk("R3", "gate", v_a, exp_vec(P_CLK_OFF));
      if (at == 0) begin
         wake = 1;
         dwell(P_CLK_OFF, P_CLK_ON, "R9");
         chk("R9", "no-cancel copy", v_b, exp_vec(P_ISO));
         wake = 0;
      end else begin
         dwell(P_CLK_OFF, P_ISO, "R4");
         if (at == 1) begin
            wake = 1;
            dwell(P_ISO, P_UNISO, "R9");
            chk("R9", "no-cancel copy", v_b, exp_vec(P_RET));
            wake = 0;
         end else begin
            dwell(P_ISO, P_RET, "R4");
            wake = 1;
            dwell(P_RET, P_UNRET, "R9");
            chk("R9", "no-cancel copy", v_b, exp_vec(P_PDN));
            wake = 0;
            dwell(P_UNRET, P_UNISO, "R9");
         end
         dwell(P_UNISO, P_CLK_ON, "R9");
      end
      dwell(P_CLK_ON, P_REL, "R9");
      settle();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd4711));
      repeat (3) tick();
      chk("R11", "reset A", v_a, exp_vec(P_RUN));
      chk("R11", "reset B", v_b, exp_vec(P_RUN));
      rst_n = 1;
      tick();
      chk("R11", "after reset", v_a, exp_vec(P_RUN));

      // R12: gated entry conditions.
      sleeping = 1; deep = 1; en = 0;
      for (int i = 0; i < 4; i++) begin tick(); chk("R12", "detector off", v_a, exp_vec(P_RUN)); end
      en = 1; deep = 0;
      for (int i = 0; i < 4; i++) begin tick(); chk("R12", "shallow sleep", v_a, exp_vec(P_RUN)); end
      sleeping = 0; en = 0;
      tick();

      // R2: no acknowledge, processor wakes by itself.
      sleeping = 1; deep = 1; en = 1;
      tick(); chk("R1", "request", v_a, exp_vec(P_HOLD));
      for (int i = 0; i < 3; i++) begin tick(); chk("R2", "no ack", v_a, exp_vec(P_HOLD)); end
      sleeping = 0; deep = 0; en = 0;
      tick(); chk("R2", "back out", v_a, exp_vec(P_RUN));
      chk("R2", "back out copy", v_b, exp_vec(P_RUN));

      // Directed corners: immediate ack, minimum waits.
      full_cycle(0, S - 1, S - 1);
      full_cycle(2, S + 4, S + 3);
      abort_cycle(0);
      abort_cycle(1);
      abort_cycle(2);

      // Constrained random latencies and abort points.
      for (int it = 0; it < 8; it++) begin
         full_cycle(int'($urandom_range(0, 4)), S - 1 + int'($urandom_range(0, 5)),
                    S - 1 + int'($urandom_range(0, 5)));
         abort_cycle(int'($urandom_range(0, 2)));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule